// File: doc/BRIEF.md
# Router Operation Mailbox Engine

This block is the command mailbox of a device router. Host software reaches it over a plain register bus with one write strobe and a combinational read port. Software first fills a metadata word, and for writes also a sixteen-dword data window. It then writes an opcode word with its valid bit set. The engine runs the operation against an internal nonvolatile store, which is modelled as a RAM, or against a computed read-only descriptor ROM. When the operation ends, the engine clears the valid bit and reports a status code, or it raises a not-supported flag. Software polls the valid bit until it reads zero.

Register addresses: 0 to 15 are the data window, 16 is the metadata word and 17 is the opcode word. Any other address reads as zero. The opcode word has this layout: bit 31 is the valid bit, bit 30 is the not-supported flag, bits 27:24 are the status and bits 15:0 are the opcode. The remaining bits read as zero. The bus carries no streaming data, so it has no handshake. Software finds out that an operation has completed only by polling the valid bit.

Top module: `router_op_mailbox`

## Requirements
- R1: After reset, every register reads zero: the window, the metadata word and the opcode word.
- R2: A bus write to address 17 with bit 31 set, made while the engine is idle, starts an operation. Bit 31 reads 1 until exactly LAT_CYCLES+n+1 clock edges after the issuing edge, and reads 0 from then on. Here n is the number of dwords moved, and n is 0 when the operation moves no data or fails its range check.
- R3: An opcode outside 0x20..0x25 is not run. This covers 0x10, 0x11 and 0x12. Bit 30 is set, the status is 0 and bit 31 clears one edge after the issuing edge.
- R4: NVM read (0x22) takes the dword offset from metadata bits 23:2 and the count from bits 27:24, where a count of 0 means 16. It copies store words offset..offset+n-1 into window entries 0..n-1 and reports status 0.
- R5: Descriptor read (0x24) takes the dword address from bits 14:2 and the count from bits 19:15, where 0 means 16. ROM word i equals 0x5A000000 + i*0x00010001, and the ROM holds ROM_WORDS words. The words are copied into the window and the status is 0.
- R6: Set offset (0x23) loads the write pointer from bits 23:2 and reports status 0. An offset of NVM_WORDS or more reports status 1 and leaves the pointer unchanged.
- R7: NVM write (0x20) stores window entries 0..n-1 at the write pointer, with n taken from bits 27:24 (0 means 16). The pointer then advances by n.
- R8: An NVM read or write whose range passes NVM_WORDS, or a descriptor read with a count above 16 or a range past ROM_WORDS, reports status 1. It moves no data and leaves the window unchanged.
- R9: Sector-size query (0x25) writes SECTOR_BYTES into metadata bits 23:0, with the upper bits zero, and reports status 0.
- R10: Authenticate (0x21) reports status 0 when store word 0 equals AUTH_MAGIC and status 1 otherwise.
- R11: While an operation is in progress, every bus write is ignored. A write to address 17 with bit 31 clear is ignored at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |

## Verification
Stored patterns are read back at more than one offset and with the count field both explicit and zero. This shows whether the offset and count are decoded, and whether the write pointer advances between two writes. Descriptor reads run at an interior address, at the exact upper edge, with a count of 17 and with a range past the end. These cases separate the inclusive bound from an off-by-one error. Authenticate runs once before the magic word is stored and once after, so a constant answer fails one of the two runs. Every cycle of every operation compares the valid bit with the predicted completion edge, which detects both latency errors and writes that should have been ignored.

// File: rtl/rmb_pkg.sv
package rmb_pkg;
  localparam int WIN_DWORDS = 16;
  localparam logic [4:0] ADDR_META = 5'd16;
  localparam logic [4:0] ADDR_OPC  = 5'd17;

  typedef enum logic [2:0] {
    K_NONE, K_WRITE, K_AUTH, K_READ, K_SETOFF, K_ROM, K_SECT
  } op_kind_t;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_XFER, S_FIN} eng_state_t;

  function automatic logic [31:0] rom_word(input int unsigned i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0001;
  endfunction
endpackage

// File: rtl/rmb_field_decode.sv
module rmb_field_decode
  import rmb_pkg::*;
(
  input  logic [15:0] op,
  input  logic [27:2] md,
  output op_kind_t    kind,
  output logic        supported,
  output logic [21:0] nvm_off,
  output logic [4:0]  nvm_cnt,
  output logic [12:0] rom_addr,
  output logic [4:0]  rom_cnt,
  output logic        rom_cnt_ok
);
  always_comb begin
    case (op)
      16'h0020: kind = K_WRITE;
      16'h0021: kind = K_AUTH;
      16'h0022: kind = K_READ;
      16'h0023: kind = K_SETOFF;
      16'h0024: kind = K_ROM;
      16'h0025: kind = K_SECT;
      default:  kind = K_NONE;
    endcase
    supported = (kind != K_NONE);
  end

  assign nvm_off    = md[23:2];
  assign nvm_cnt    = (md[27:24] == 4'd0) ? 5'd16 : {1'b0, md[27:24]};
  assign rom_addr   = md[14:2];
  assign rom_cnt    = (md[19:15] == 5'd0) ? 5'd16 : md[19:15];
  assign rom_cnt_ok = (rom_cnt <= 5'd16);
endmodule

// File: rtl/rmb_nvm_store.sv
module rmb_nvm_store #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rmb_desc_rom.sv
module rmb_desc_rom
  import rmb_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic [AW-1:0] addr,
  output logic [31:0]   data
);
  logic [31:0] table_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_rom
    assign table_q[g] = rom_word(g);
  end

  assign data = table_q[addr];
endmodule

// File: rtl/router_op_mailbox.sv
module router_op_mailbox
  import rmb_pkg::*;
#(
  parameter int          LAT_CYCLES   = 4,
  parameter int          NVM_WORDS    = 256,
  parameter int          ROM_WORDS    = 64,
  parameter int          SECTOR_BYTES = 4096,
  parameter logic [31:0] AUTH_MAGIC   = 32'h4E56_4D31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam int NVM_AW = $clog2(NVM_WORDS);
  localparam int ROM_AW = $clog2(ROM_WORDS);
  localparam int LATW   = $clog2(LAT_CYCLES + 1);

  logic [31:0] win [WIN_DWORDS];
  logic [31:0] meta;
  logic [15:0] opc_code;
  logic        opc_valid, opc_ons;
  logic [3:0]  opc_status;
  logic [21:0] nvm_ptr, xfer_base;
  logic [4:0]  idx, xfer_n;
  logic [LATW-1:0] lat_cnt;
  logic [3:0]  fin_status;
  logic        fin_ons;
  eng_state_t  state;
  op_kind_t    cur_kind;

  op_kind_t    dec_kind;
  logic        dec_sup, rom_cnt_ok;
  logic [21:0] nvm_off;
  logic [4:0]  nvm_cnt, rom_cnt;
  logic [12:0] rom_addr;

  rmb_field_decode u_dec (
    .op(bus_wdata[15:0]), .md(meta[27:2]), .kind(dec_kind), .supported(dec_sup),
    .nvm_off(nvm_off), .nvm_cnt(nvm_cnt), .rom_addr(rom_addr),
    .rom_cnt(rom_cnt), .rom_cnt_ok(rom_cnt_ok)
  );

  logic              nvm_we;
  logic [NVM_AW-1:0] nvm_waddr, nvm_raddr;
  logic [31:0]       nvm_rdata, rom_rdata;
  logic [ROM_AW-1:0] rom_a;

  assign nvm_we    = (state == S_XFER) && (cur_kind == K_WRITE);
  assign nvm_waddr = NVM_AW'(xfer_base + 22'(idx));
  assign nvm_raddr = (state == S_XFER) ? NVM_AW'(xfer_base + 22'(idx)) : '0;
  assign rom_a     = ROM_AW'(xfer_base + 22'(idx));

  rmb_nvm_store #(.WORDS(NVM_WORDS)) u_nvm (
    .clk(clk), .we(nvm_we), .waddr(nvm_waddr), .wdata(win[idx[3:0]]),
    .raddr(nvm_raddr), .rdata(nvm_rdata)
  );

  rmb_desc_rom #(.WORDS(ROM_WORDS)) u_rom (.addr(rom_a), .data(rom_rdata));

  // Range and result evaluation at the end of the latency window
  logic [21:0] chk_base;
  logic [4:0]  chk_n;
  logic        chk_ok, chk_xfer;
  always_comb begin
    chk_base = '0;
    chk_n    = nvm_cnt;
    chk_ok   = 1'b1;
    chk_xfer = 1'b0;
    case (cur_kind)
      K_READ: begin
        chk_base = nvm_off;
        chk_ok   = (32'(nvm_off) + 32'(nvm_cnt)) <= 32'(NVM_WORDS);
        chk_xfer = 1'b1;
      end
      K_WRITE: begin
        chk_base = nvm_ptr;
        chk_ok   = (32'(nvm_ptr) + 32'(nvm_cnt)) <= 32'(NVM_WORDS);
        chk_xfer = 1'b1;
      end
      K_ROM: begin
        chk_base = 22'(rom_addr);
        chk_n    = rom_cnt;
        chk_ok   = rom_cnt_ok && ((32'(rom_addr) + 32'(rom_cnt)) <= 32'(ROM_WORDS));
        chk_xfer = 1'b1;
      end
      K_SETOFF: chk_ok = 32'(nvm_off) < 32'(NVM_WORDS);
      K_AUTH:   chk_ok = (nvm_rdata == AUTH_MAGIC);
      default:  chk_ok = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WIN_DWORDS; i++) win[i] <= '0;
      meta <= '0; opc_code <= '0; opc_valid <= 1'b0; opc_ons <= 1'b0;
      opc_status <= '0; nvm_ptr <= '0; xfer_base <= '0; idx <= '0;
      xfer_n <= '0; lat_cnt <= '0; fin_status <= '0; fin_ons <= 1'b0;
      state <= S_IDLE; cur_kind <= K_NONE;
    end else begin
      case (state)
        S_IDLE: if (bus_wr) begin
          if (!bus_addr[4]) win[bus_addr[3:0]] <= bus_wdata;
          else if (bus_addr == ADDR_META) meta <= bus_wdata;
          else if (bus_addr == ADDR_OPC && bus_wdata[31]) begin
            opc_code   <= bus_wdata[15:0];
            opc_valid  <= 1'b1;
            opc_ons    <= 1'b0;
            opc_status <= '0;
            cur_kind   <= dec_kind;
            fin_status <= '0;
            fin_ons    <= !dec_sup;
            lat_cnt    <= LATW'(LAT_CYCLES - 1);
            state      <= dec_sup ? S_WAIT : S_FIN;
          end
        end
        S_WAIT: begin
          if (lat_cnt != '0) lat_cnt <= lat_cnt - 1'b1;
          else begin
            fin_status <= chk_ok ? 4'd0 : 4'd1;
            if (cur_kind == K_SETOFF && chk_ok) nvm_ptr <= nvm_off;
            if (cur_kind == K_SECT) meta <= {8'd0, 24'(SECTOR_BYTES)};
            if (chk_xfer && chk_ok) begin
              xfer_base <= chk_base;
              xfer_n    <= chk_n;
              idx       <= '0;
              state     <= S_XFER;
            end else begin
              state <= S_FIN;
            end
          end
        end
        S_XFER: begin
          if (cur_kind == K_READ) win[idx[3:0]] <= nvm_rdata;
          if (cur_kind == K_ROM)  win[idx[3:0]] <= rom_rdata;
          if (idx == xfer_n - 5'd1) begin
            if (cur_kind == K_WRITE) nvm_ptr <= nvm_ptr + 22'(xfer_n);
            state <= S_FIN;
          end else begin
            idx <= idx + 5'd1;
          end
        end
        S_FIN: begin
          opc_valid  <= 1'b0;
          opc_status <= fin_status;
          opc_ons    <= fin_ons;
          state      <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!bus_addr[4])               bus_rdata = win[bus_addr[3:0]];
    else if (bus_addr == ADDR_META) bus_rdata = meta;
    else if (bus_addr == ADDR_OPC)
      bus_rdata = {opc_valid, opc_ons, 2'b00, opc_status, 8'h00, opc_code};
    else                            bus_rdata = '0;
  end

  // R2: valid stays set for the whole life of an operation
  a_r2_busy_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |-> opc_valid);
  // R2: completion returns to idle with valid cleared
  a_r2_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FIN) |=> (state == S_IDLE) && !opc_valid);
  // R3: a not-supported result carries a zero status and no pending work
  a_r3_ons_clean: assert property (@(posedge clk) disable iff (!rst_n)
    opc_ons |-> (!opc_valid && opc_status == 4'd0));
  // R4: transfer index stays inside the requested count
  a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_XFER) |-> (idx < xfer_n) && (xfer_n <= 5'd16));
  // R11: bus writes during an operation leave the opcode untouched
  a_r11_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && bus_wr) |=> $stable(opc_code));
endmodule

// File: tb/router_op_mailbox_tb.sv
module router_op_mailbox_tb;
  localparam int LAT = 4;
  localparam int NVW = 256;
  localparam int ROW = 64;
  localparam int SECT = 4096;
  localparam logic [31:0] MAGIC = 32'h4E56_4D31;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [4:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  router_op_mailbox #(.LAT_CYCLES(LAT), .NVM_WORDS(NVW), .ROM_WORDS(ROW),
    .SECTOR_BYTES(SECT), .AUTH_MAGIC(MAGIC)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(wr_en), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata));

  // Behavioural reference state
  logic [31:0] m_win [16];
  logic [31:0] m_nvm [NVW];
  logic [31:0] m_meta, m_opc;
  int m_ptr;

  function automatic logic [31:0] rom_ref(int i);
    return 32'h5A00_0000 + 32'(i) * 32'h0001_0001;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bw(logic [4:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic check_regs(string req);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin rd(5'(i), v); chk(req, v, m_win[i]); end
    rd(5'd16, v); chk(req, v, m_meta);
    rd(5'd17, v); chk(req, v, m_opc);
  endtask

  task automatic wr_win(int i, logic [31:0] d);
    bw(5'(i), d); m_win[i] = d;
  endtask

  task automatic run_op(logic [15:0] code, logic [31:0] md, bit poke, string req);
    int t, n, c, a;
    logic [3:0] st;
    bit ons;
    logic [31:0] v;
    n = 0; st = 0; ons = 0;
    bw(5'd16, md); m_meta = md;
    case (code)
      16'h22: begin
        a = int'(md[23:2]); c = (md[27:24] == 0) ? 16 : int'(md[27:24]);
        if (a + c <= NVW) begin for (int i = 0; i < c; i++) m_win[i] = m_nvm[a+i]; n = c; end
        else st = 1;
      end
      16'h20: begin
        c = (md[27:24] == 0) ? 16 : int'(md[27:24]);
        if (m_ptr + c <= NVW) begin
          for (int i = 0; i < c; i++) m_nvm[m_ptr+i] = m_win[i];
          m_ptr += c; n = c;
        end else st = 1;
      end
      16'h24: begin
        a = int'(md[14:2]); c = (md[19:15] == 0) ? 16 : int'(md[19:15]);
        if (c <= 16 && a + c <= ROW) begin for (int i = 0; i < c; i++) m_win[i] = rom_ref(a+i); n = c; end
        else st = 1;
      end
      16'h23: if (int'(md[23:2]) < NVW) m_ptr = int'(md[23:2]); else st = 1;
      16'h25: m_meta = 32'(SECT);
      16'h21: st = (m_nvm[0] === MAGIC) ? 4'd0 : 4'd1;
      default: ons = 1;
    endcase
    t = ons ? 1 : LAT + n + 1;
    bw(5'd17, 32'h8000_0000 | 32'(code));
    for (int k = 0; k <= t; k++) begin
      if (poke && k == 1) begin wr_en = 1; wdata = 32'h8000_0025; end
      if (poke && k == 2) wr_en = 0;
      rd(5'd17, v);
      chk({req, " valid timing (R2)"}, {31'd0, v[31]}, {31'd0, (k < t)});
      if (k < t) @(negedge clk);
    end
    m_opc = {1'b0, ons, 2'b00, st, 8'h00, code};
    check_regs(req);
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16; i++) m_win[i] = '0;
    for (int i = 0; i < NVW; i++) m_nvm[i] = '0;
    m_meta = '0; m_opc = '0; m_ptr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_regs("R1 reset");
    rd(5'd20, v); chk("R1 unmapped", v, 32'd0);

    for (int i = 0; i < 16; i++) wr_win(i, 32'hA000_0000 + 32'(i * 7));
    run_op(16'h23, 32'd0, 0, "R6 set offset 0");
    run_op(16'h20, 32'h0400_0000, 0, "R7 write 4");
    for (int i = 0; i < 16; i++) wr_win(i, 32'hB100_0000 ^ 32'(i * 13));
    run_op(16'h20, 32'h0000_0000, 0, "R7 write 16 at advanced ptr");
    for (int i = 0; i < 16; i++) wr_win(i, 32'h0);
    run_op(16'h22, 32'h0300_0004, 0, "R4 read off1 cnt3");
    run_op(16'h22, 32'h0000_0008, 0, "R4 read off2 cnt16");
    run_op(16'h22, 32'h0800_0000 | (32'd250 << 2), 0, "R8 nvm read out of range");
    run_op(16'h24, (32'd5 << 15) | (32'd10 << 2), 0, "R5 rom read");
    run_op(16'h24, (32'd0 << 15) | (32'd48 << 2), 0, "R5 rom read edge cnt0");
    run_op(16'h24, (32'd17 << 15) | (32'd0 << 2), 0, "R8 rom count 17");
    run_op(16'h24, (32'd8 << 15) | (32'd60 << 2), 0, "R8 rom past end");
    run_op(16'h23, 32'd300 << 2, 0, "R6 offset out of range");
    run_op(16'h23, 32'd250 << 2, 0, "R6 offset 250");
    run_op(16'h20, 32'h0800_0000, 0, "R8 nvm write past end");
    run_op(16'h25, 32'hFFFF_FFFF, 0, "R9 sector size");
    run_op(16'h21, 32'd0, 0, "R10 auth bad image");
    run_op(16'h23, 32'd0, 0, "R6 offset back to 0");
    wr_win(0, MAGIC);
    run_op(16'h20, 32'h0100_0000, 0, "R7 write magic");
    run_op(16'h21, 32'd0, 0, "R10 auth good image");
    run_op(16'h10, 32'd0, 0, "R3 query");
    run_op(16'h11, 32'd0, 0, "R3 alloc");
    run_op(16'h12, 32'd0, 0, "R3 release");
    run_op(16'h0120, 32'd0, 0, "R3 wide opcode");
    run_op(16'h22, 32'h0200_0000, 1, "R11 busy write ignored");
    bw(5'd17, 32'h0000_0023);
    rd(5'd17, v); chk("R11 write without valid", v, m_opc);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule